// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Driver

This block runs four seven-segment digits that share a single segment bus. It turns on one digit-select line at a time and moves to the next digit on every pulse of a refresh tick, so each digit is lit for one tick period in every four. A prescaled timer supplies the tick. With a tick period of 3.2 ms to 5 ms, the whole display refreshes every 12.8 ms to 20 ms, which the eye sees as four steady digits.

Each digit slot holds an ASCII character. The block subtracts the code of '0' (0x30) from it and maps the result to a segment pattern. A character that is not a decimal digit leaves its digit dark. The host writes characters one at a time into a shadow buffer and then pulses a commit strobe. The commit takes a snapshot of all four characters at once. The snapshot reaches the visible buffer only at the next frame boundary, which is the tick that wraps the scan back to digit 0. A frame therefore never shows part of an old number together with part of a new one.

Top module: `seg_mux_drv`

## Requirements
- R1: After reset all four digit selects are off and the segment bus is all zero. The visible buffer holds "0000", so the first tick lights digit 0 with the pattern for '0' (0111111).
- R2: At most one select line is high at a time. Scan index i drives select bit 3-i, so index 0 (leftmost) gives 1000, index 1 gives 0100, index 2 gives 0010 and index 3 gives 0001. While no select is active, the segment bus is zero.
- R3: The scan index moves exactly once per cycle in which tick is high, in the order 0, 1, 2, 3 and then back to 0. With tick low, the select lines and segments hold their values.
- R4: A character c in '0'..'9' shows digit value c-0x30. The segment bus is ordered {g,f,e,d,c,b,a} and is active high: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R5: A character outside '0'..'9' (for example ' ', '/', ':', '~') drives all seven segments off while its digit is selected.
- R6: A write strobe stores wrChar into shadow slot wrIdx (0 is the leftmost digit). Writes without a commit never change what is displayed.
- R7: A commit pulse takes a snapshot of the shadow buffer. The snapshot becomes visible on the tick that moves the scan from index 3 to index 0, all four digits together. Digits shown before that tick keep their old values.
- R8: Shadow writes made after a commit and before the next frame boundary are not part of that pending update. They appear only after a later commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Refresh pulse, one cycle wide; advances the scan |
| wrEn | input | 1 | Write strobe into the shadow buffer |
| wrIdx | input | 2 | Shadow slot to write, 0 = leftmost |
| wrChar | input | 8 | ASCII character to store |
| commit | input | 1 | Snapshot the shadow buffer for the next frame |
| segOut | output | 7 | Segment pattern {g,f,e,d,c,b,a}, active high |
| digSel | output | 4 | Digit selects, one-hot or all off |

## Verification
The decoder is tested with all ten ASCII digits spread across all four positions. It is also tested with characters just below '0' and just above '9' and with punctuation, which separates a correct subtract-and-range check from a decoder that masks the low nibble. Updates are tested in three patterns: writes with no commit, a commit issued in the middle of a frame, and writes made between a commit and the frame boundary. Together these separate a correct snapshot-at-commit, load-at-wrap design from designs that copy on every tick, copy right away, or copy the live shadow buffer at the boundary. The select order is checked for a full sweep and for the wrap from 3 to 0, and the outputs are checked to hold while tick stays low.

// File: rtl/segmux_pkg.sv
package segmux_pkg;
  localparam int DIGIT_COUNT = 4;
  localparam int IDX_W = $clog2(DIGIT_COUNT);
  localparam int CHAR_W = 8;
  localparam int SEG_W = 7;
  localparam logic [CHAR_W-1:0] ASCII_ZERO = 8'h30;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // snapshot shadow into held buffer
    logic loadDisp;  // move held buffer to visible buffer
    logic active;    // scan has started
    logic [IDX_W-1:0] idx;
  } ctrl_strobe_t;

  // ASCII digit to {g,f,e,d,c,b,a}; anything else blanks
  function automatic logic [SEG_W-1:0] charToSeg(input logic [CHAR_W-1:0] ch);
    logic [CHAR_W-1:0] val;
    val = ch - ASCII_ZERO;
    case (val)
      8'd0: charToSeg = 7'b0111111;
      8'd1: charToSeg = 7'b0000110;
      8'd2: charToSeg = 7'b1011011;
      8'd3: charToSeg = 7'b1001111;
      8'd4: charToSeg = 7'b1100110;
      8'd5: charToSeg = 7'b1101101;
      8'd6: charToSeg = 7'b1111101;
      8'd7: charToSeg = 7'b0000111;
      8'd8: charToSeg = 7'b1111111;
      8'd9: charToSeg = 7'b1101111;
      default: charToSeg = '0;
    endcase
  endfunction
endpackage

// File: rtl/segmux_ctrl.sv
module segmux_ctrl
  import segmux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic commit,
  output ctrl_strobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGIT_COUNT - 1);

  logic [IDX_W-1:0] curIdx;
  logic active;
  logic pending;
  logic atWrap;
  logic frameEdge;

  assign atWrap = (curIdx == LAST_IDX);
  assign frameEdge = tick && atWrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curIdx  <= LAST_IDX;
      active  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (tick) begin
        curIdx <= atWrap ? '0 : curIdx + 1'b1;
        active <= 1'b1;
      end
      if (commit) pending <= 1'b1;
      else if (frameEdge) pending <= 1'b0;
    end
  end

  always_comb begin
    strobe.capture  = commit;
    strobe.loadDisp = frameEdge && pending;
    strobe.active   = active;
    strobe.idx      = curIdx;
  end
endmodule

// File: rtl/segmux_data.sv
module segmux_data
  import segmux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [CHAR_W-1:0] wrChar,
  input  ctrl_strobe_t strobe,
  output logic [SEG_W-1:0] segOut,
  output logic [DIGIT_COUNT-1:0] digSel
);
  logic [CHAR_W-1:0] shadowBuf [DIGIT_COUNT];
  logic [CHAR_W-1:0] heldBuf [DIGIT_COUNT];
  logic [CHAR_W-1:0] dispBuf [DIGIT_COUNT];

  for (genvar g = 0; g < DIGIT_COUNT; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadowBuf[g] <= ASCII_ZERO;
        heldBuf[g]   <= ASCII_ZERO;
        dispBuf[g]   <= ASCII_ZERO;
      end else begin
        if (wrEn && (wrIdx == IDX_W'(g))) shadowBuf[g] <= wrChar;
        if (strobe.capture) heldBuf[g] <= shadowBuf[g];
        if (strobe.loadDisp) dispBuf[g] <= heldBuf[g];
      end
    end
    // leftmost digit (index 0) sits on the top select bit
    assign digSel[g] = strobe.active && (strobe.idx == IDX_W'(DIGIT_COUNT - 1 - g));
  end

  always_comb begin
    segOut = '0;
    if (strobe.active) segOut = charToSeg(dispBuf[strobe.idx]);
  end
endmodule

// File: rtl/seg_mux_drv.sv
module seg_mux_drv
  import segmux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic commit,
  output logic [SEG_W-1:0] segOut,
  output logic [DIGIT_COUNT-1:0] digSel
);
  ctrl_strobe_t strobe;

  segmux_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit), .strobe(strobe)
  );

  segmux_data i_data (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrChar(wrChar),
    .strobe(strobe), .segOut(segOut), .digSel(digSel)
  );
endmodule

// File: rtl/segmux_chk.sv
module segmux_chk
  import segmux_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic [SEG_W-1:0] segOut,
  input logic [DIGIT_COUNT-1:0] digSel
);
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digSel));

  assert_dark_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (digSel == '0) |-> (segOut == '0));

  assert_hold_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digSel));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && digSel == 4'b0001) |=> (digSel == 4'b1000));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && digSel == 4'b1000) |=> (digSel == 4'b0100));

  // visible content only moves on a tick
  assert_seg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(segOut));
endmodule

bind seg_mux_drv segmux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .segOut(segOut), .digSel(digSel)
);

// File: tb/test_seg_mux_drv.sv
module test_seg_mux_drv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrIdx = '0;
  logic [7:0] wrChar = '0;
  logic commit = 1'b0;
  logic [6:0] segOut;
  logic [3:0] digSel;

  int errors = 0;
  int checks = 0;
  int expIdx = 3;

  always #10 clk = ~clk;

  seg_mux_drv i_seg_mux_drv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrChar(wrChar), .commit(commit), .segOut(segOut), .digSel(digSel)
  );

  function automatic logic [6:0] expSeg(input logic [7:0] c);
    case (c)
      "0": return 7'b0111111;
      "1": return 7'b0000110;
      "2": return 7'b1011011;
      "3": return 7'b1001111;
      "4": return 7'b1100110;
      "5": return 7'b1101101;
      "6": return 7'b1111101;
      "7": return 7'b0000111;
      "8": return 7'b1111111;
      "9": return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic stepTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    expIdx = (expIdx + 1) % 4;
  endtask

  task automatic writeChar(input int idx, input logic [7:0] c);
    @(negedge clk) begin wrEn = 1'b1; wrIdx = 2'(idx); wrChar = c; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic writeAll(input string s);
    for (int i = 0; i < 4; i++) writeChar(i, s[i]);
  endtask

  task automatic doCommit();
    @(negedge clk) commit = 1'b1;
    @(negedge clk) commit = 1'b0;
  endtask

  task automatic checkDigit(input string req, input logic [7:0] c);
    logic [3:0] es;
    es = 4'b1000 >> expIdx;
    chk(digSel == es, req, "select", int'(digSel), int'(es));
    chk(segOut == expSeg(c), req, "segments", int'(segOut), int'(expSeg(c)));
  endtask

  task automatic toFrameEnd();
    while (expIdx != 3) stepTick();
  endtask

  task automatic scanFrame(input string req, input string s);
    toFrameEnd();
    for (int i = 0; i < 4; i++) begin
      stepTick();
      checkDigit(req, s[expIdx]);
    end
  endtask

  task automatic testReset();
    chk(digSel == 4'b0000, "R1", "select after reset", int'(digSel), 0);
    chk(segOut == 7'b0, "R1", "segments after reset", int'(segOut), 0);
    stepTick();
    checkDigit("R1", "0");
    chk(segOut == 7'b0111111, "R1", "zero pattern", int'(segOut), 7'b0111111);
    for (int i = 1; i < 4; i++) begin
      stepTick();
      checkDigit("R2", "0");
    end
    stepTick();
    chk(digSel == 4'b1000, "R3", "wrap to leftmost", int'(digSel), 4'b1000);
  endtask

  task automatic testHold();
    logic [3:0] s0;
    logic [6:0] g0;
    s0 = digSel;
    g0 = segOut;
    repeat (6) @(negedge clk);
    chk(digSel == s0, "R3", "select held without tick", int'(digSel), int'(s0));
    chk(segOut == g0, "R3", "segments held without tick", int'(segOut), int'(g0));
  endtask

  task automatic testNoCommit();
    writeAll("1942");
    scanFrame("R6", "0000");
    scanFrame("R6", "0000");
  endtask

  task automatic testCommitBoundary();
    toFrameEnd();
    stepTick();
    doCommit();
    for (int i = 0; i < 3; i++) begin
      stepTick();
      checkDigit("R7", "0");
    end
    scanFrame("R7", "1942");
    stepTick();
    stepTick();
    chk(segOut == 7'b1101111, "R4", "nine pattern on index 1", int'(segOut), 7'b1101111);
    chk(digSel == 4'b0100, "R2", "index 1 select", int'(digSel), 4'b0100);
  endtask

  task automatic testSnapshot();
    writeAll("2014");
    doCommit();
    writeAll("5678");
    scanFrame("R8", "2014");
    scanFrame("R8", "2014");
    doCommit();
    scanFrame("R8", "5678");
  endtask

  task automatic testDecode();
    writeAll("0123");
    doCommit();
    scanFrame("R4", "0123");
    writeAll("4567");
    doCommit();
    scanFrame("R4", "4567");
    writeAll("89/:");
    doCommit();
    scanFrame("R5", "89/:");
    writeAll(" 0~5");
    doCommit();
    scanFrame("R5", " 0~5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testNoCommit();
    testCommitBoundary();
    testHold();
    testSnapshot();
    testDecode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule